// File: doc/BRIEF.md
# Selectable-Operand Arithmetic Unit

This combinational unit adds two N-bit words and a carry-in. One word, A, goes straight into a ripple-carry adder. The other adder input is chosen per bit by a two-bit source select from four candidates: B, the bitwise inverse of B, all zeros, or all ones. The four select codes and the two carry-in values give eight arithmetic operations from one adder: add, add with carry, subtract with borrow, subtract, increment, decrement, and two ways to pass A through unchanged.

The unit has no state. A datapath places A, B, the source code and the carry-in on the inputs. The N-bit result and the carry-out of the top stage are valid once the carry has rippled through the chain. The carry-out is the only flag.

Top module: `selop_arith_unit`

## Requirements
- R1: With source code 2'b00 the second operand is B, and {cout_o, d_o} equals A + B + cin_i as an (N+1)-bit sum. With carry-in 0 this is a plain add; with carry-in 1 it is an add with carry.
- R2: With source code 2'b01 the second operand is ~B. With carry-in 0, d_o = A - B - 1 modulo 2^N and cout_o = 1 exactly when A > B. With carry-in 1, d_o = A - B modulo 2^N and cout_o = 1 exactly when A >= B.
- R3: With source code 2'b10 the second operand is zero. d_o = A when carry-in is 0 and A + 1 modulo 2^N when carry-in is 1. cout_o is 1 only when A is all ones and carry-in is 1.
- R4: With source code 2'b11 the second operand is all ones. With carry-in 0, d_o = A - 1 modulo 2^N and cout_o = 1 unless A is zero. With carry-in 1, d_o = A and cout_o = 1.
- R5: Incrementing all ones (code 2'b10, carry-in 1) gives d_o = 0 and cout_o = 1.
- R6: Decrementing zero (code 2'b11, carry-in 0) gives d_o = all ones and cout_o = 0.
- R7: With source code 2'b10 or 2'b11, the value of B has no effect on d_o or cout_o.
- R8: For every code, carry-in and operand pair, cout_o equals bit N of the (N+1)-bit sum of A, the selected operand and carry-in. The outputs settle in the same cycle the inputs are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | Operand fed straight to the adder |
| b_i | input | N | Operand routed through the source selector |
| sel_i | input | 2 | Source of the second adder input: 00 B, 01 ~B, 10 zero, 11 all ones |
| cin_i | input | 1 | Carry into the least significant stage |
| d_o | output | N | Sum |
| cout_o | output | 1 | Carry out of the most significant stage |

## Verification
There is no internal state. A fault in the source selector or in one adder stage therefore shows up on d_o or cout_o in the same cycle as the input pattern that exposes it. A broken selector leg, such as a wrong polarity on the inverted-B path or a swapped constant, corrupts one whole pair of operations. A broken carry link shows only for operand pairs whose carry reaches that stage. For that reason all codes, carry-ins and operand pairs are checked at the default width, with the wrap-around corners and the independence from B checked by name.

// File: rtl/selop_pkg.sv
package selop_pkg;

  // Source of the second adder operand; the code values are part of the
  // block's external behaviour.
  typedef enum logic [1:0] {
    YSRC_B    = 2'b00,
    YSRC_NOTB = 2'b01,
    YSRC_ZERO = 2'b10,
    YSRC_ONES = 2'b11
  } ysrc_e;

endpackage

// File: rtl/selop_operand_mux.sv
module selop_operand_mux
  import selop_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0] b_i,
  input  ysrc_e        src_i,
  output logic [N-1:0] y_o
);

  // One 4:1 selector per bit, all sharing the same select.
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_comb begin
      unique case (src_i)
        YSRC_B:    y_o[g] = b_i[g];
        YSRC_NOTB: y_o[g] = ~b_i[g];
        YSRC_ZERO: y_o[g] = 1'b0;
        YSRC_ONES: y_o[g] = 1'b1;
        default:   y_o[g] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/selop_full_adder.sv
module selop_full_adder (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);

  logic half;

  always_comb begin
    half = x_i ^ y_i;
    s_o  = half ^ c_i;
    c_o  = (x_i & y_i) | (half & c_i);
  end

endmodule

// File: rtl/selop_ripple_adder.sv
module selop_ripple_adder #(
  parameter int N = 4
) (
  input  logic [N-1:0] x_i,
  input  logic [N-1:0] y_i,
  input  logic         cin_i,
  output logic [N-1:0] s_o,
  output logic         cout_o
);

  localparam int NC = N + 1;

  logic [NC-1:0] carry;

  assign carry[0] = cin_i;

  for (genvar g = 0; g < N; g++) begin : g_stage
    selop_full_adder u_fa (
      .x_i (x_i[g]),
      .y_i (y_i[g]),
      .c_i (carry[g]),
      .s_o (s_o[g]),
      .c_o (carry[g+1])
    );
  end

  assign cout_o = carry[N];

  // R8
  always_comb begin
    ripple_sum_chk: assert ({cout_o, s_o} ==
                            ({1'b0, x_i} + {1'b0, y_i} + {{N{1'b0}}, cin_i}))
      else $error("ripple chain sum mismatch");
  end

endmodule

// File: rtl/selop_arith_unit.sv
module selop_arith_unit
  import selop_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic [1:0]   sel_i,
  input  logic         cin_i,
  output logic [N-1:0] d_o,
  output logic         cout_o
);

  localparam logic [N-1:0] ALL_ONES = {N{1'b1}};

  ysrc_e        src;
  logic [N-1:0] y_sel;

  assign src = ysrc_e'(sel_i);

  selop_operand_mux #(.N(N)) u_mux (
    .b_i   (b_i),
    .src_i (src),
    .y_o   (y_sel)
  );

  selop_ripple_adder #(.N(N)) u_add (
    .x_i    (a_i),
    .y_i    (y_sel),
    .cin_i  (cin_i),
    .s_o    (d_o),
    .cout_o (cout_o)
  );

  always_comb begin
    // R1
    add_mode_chk: assert (sel_i != 2'b00 ||
                          {cout_o, d_o} == ({1'b0, a_i} + {1'b0, b_i} + {{N{1'b0}}, cin_i}))
      else $error("add mode mismatch");
    // R2
    sub_mode_chk: assert (sel_i != 2'b01 ||
                          (d_o == a_i - b_i - {{(N-1){1'b0}}, ~cin_i} &&
                           cout_o == (cin_i ? (a_i >= b_i) : (a_i > b_i))))
      else $error("subtract mode mismatch");
    // R3
    inc_mode_chk: assert (sel_i != 2'b10 ||
                          (d_o == a_i + {{(N-1){1'b0}}, cin_i} &&
                           cout_o == (cin_i && a_i == ALL_ONES)))
      else $error("transfer/increment mismatch");
    // R4
    dec_mode_chk: assert (sel_i != 2'b11 ||
                          (d_o == a_i - {{(N-1){1'b0}}, ~cin_i} &&
                           cout_o == (cin_i || a_i != '0)))
      else $error("decrement/transfer mismatch");
    // R5
    inc_wrap_chk: assert (!(sel_i == 2'b10 && cin_i && a_i == ALL_ONES) ||
                          (d_o == '0 && cout_o))
      else $error("increment wrap mismatch");
    // R6
    dec_wrap_chk: assert (!(sel_i == 2'b11 && !cin_i && a_i == '0) ||
                          (d_o == ALL_ONES && !cout_o))
      else $error("decrement wrap mismatch");
    // R7
    b_ignored_chk: assert (!sel_i[1] || y_sel == {N{sel_i[0]}})
      else $error("operand depends on B in constant mode");
  end

endmodule

// File: tb/selop_arith_unit_tb_top.sv
module selop_arith_unit_tb_top;

  localparam int  N        = 4;
  localparam time CLK_PER  = 10ns;
  localparam int  WATCHDOG = 200000;
  localparam int  NVEC     = 12;

  // {sel, cin, a, b, expected d, expected cout}
  localparam logic [15:0] VEC [NVEC] = '{
    {2'b00, 1'b0, 4'h3, 4'h5, 4'h8, 1'b0},  // R1 add
    {2'b00, 1'b1, 4'hF, 4'h1, 4'h1, 1'b1},  // R1 add with carry, overflow
    {2'b01, 1'b0, 4'h7, 4'h2, 4'h4, 1'b1},  // R2 subtract with borrow
    {2'b01, 1'b1, 4'h7, 4'h2, 4'h5, 1'b1},  // R2 subtract
    {2'b01, 1'b1, 4'h2, 4'h7, 4'hB, 1'b0},  // R2 subtract, A < B
    {2'b01, 1'b0, 4'h5, 4'h5, 4'hF, 1'b0},  // R2 borrow, A == B
    {2'b10, 1'b0, 4'h9, 4'h6, 4'h9, 1'b0},  // R3 transfer
    {2'b10, 1'b1, 4'hA, 4'h0, 4'hB, 1'b0},  // R3 increment
    {2'b10, 1'b1, 4'hF, 4'h3, 4'h0, 1'b1},  // R5 increment wrap
    {2'b11, 1'b0, 4'h0, 4'h4, 4'hF, 1'b0},  // R6 decrement wrap
    {2'b11, 1'b0, 4'h8, 4'h0, 4'h7, 1'b1},  // R4 decrement
    {2'b11, 1'b1, 4'h6, 4'h9, 4'h6, 1'b1}   // R4 transfer
  };

  logic         clk;
  logic         rst_n;
  logic [N-1:0] a, b, d;
  logic [1:0]   sel;
  logic         cin, cout;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  finished = 0;

  selop_arith_unit #(.N(N)) dut_i (
    .a_i    (a),
    .b_i    (b),
    .sel_i  (sel),
    .cin_i  (cin),
    .d_o    (d),
    .cout_o (cout)
  );

  initial clk = 1'b0;
  always #(CLK_PER/2) clk = ~clk;

  task automatic check(input string req, input logic [N-1:0] exp_d, input logic exp_c);
    n_checks++;
    if (d !== exp_d || cout !== exp_c) begin
      n_errors++;
      $display("FAIL %s: sel=%b cin=%b a=%h b=%h got d=%h cout=%b exp d=%h cout=%b",
               req, sel, cin, a, b, d, cout, exp_d, exp_c);
    end
  endtask

  task automatic apply(input logic [1:0] s, input logic c,
                       input logic [N-1:0] av, input logic [N-1:0] bv);
    @(posedge clk);
    sel = s; cin = c; a = av; b = bv;
    @(negedge clk);
  endtask

  function automatic string req_of(input logic [1:0] s);
    case (s)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  initial begin
    sel = '0; cin = 1'b0; a = '0; b = '0;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Quiet state: all-zero inputs give a zero sum (R1)
    check("R1 idle", 4'h0, 1'b0);

    // Directed vector table
    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][15:14], VEC[i][13], VEC[i][12:9], VEC[i][8:5]);
      check(req_of(VEC[i][15:14]), VEC[i][4:1], VEC[i][0]);
    end

    // Exhaustive sweep against an (N+1)-bit reference sum (R8)
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 2; c++) begin
        for (int ai = 0; ai < (1 << N); ai++) begin
          for (int bi = 0; bi < (1 << N); bi++) begin
            logic [N-1:0] yv;
            logic [N:0]   ref_sum;
            case (s)
              0:       yv = N'(bi);
              1:       yv = ~N'(bi);
              2:       yv = '0;
              default: yv = '1;
            endcase
            ref_sum = {1'b0, N'(ai)} + {1'b0, yv} + (N+1)'(c);
            apply(2'(s), 1'(c), N'(ai), N'(bi));
            check({req_of(2'(s)), " R8"}, ref_sum[N-1:0], ref_sum[N]);
          end
        end
      end
    end

    // R7: B changes while the code selects a constant
    for (int s = 2; s < 4; s++) begin
      for (int c = 0; c < 2; c++) begin
        logic [N-1:0] d0;
        logic         c0;
        apply(2'(s), 1'(c), 4'h9, 4'h0);
        d0 = d; c0 = cout;
        apply(2'(s), 1'(c), 4'h9, 4'hF);
        check("R7", d0, c0);
        apply(2'(s), 1'(c), 4'h9, 4'h5);
        check("R7", d0, c0);
      end
    end

    // R5 and R6 corners once more, with a non-zero B
    apply(2'b10, 1'b1, 4'hF, 4'hA);
    check("R5", 4'h0, 1'b1);
    apply(2'b11, 1'b0, 4'h0, 4'h5);
    check("R6", 4'hF, 1'b0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule